// File: doc/BRIEF.md
# Chip-Enable Watchdog and Power-Down Sequencer

This block supervises a host processor. It has two parts. The first is a watchdog that software arms with an enable bit. While armed, the watchdog needs the chip-enable line to be toggled at regular intervals. A toggle only counts when no serial clock activity happens during it. If the interval runs out, the block drives the processor reset low for a fixed pulse and sets a sticky timeout flag. The flag stays set until a status read clears it.

The second part is a power-down sequencer that the processor starts itself. Once entered, it drops the supply-enable output, gates off the clock output, holds the processor in reset and turns off the serial interface. Power-down ends when any interrupt arrives, or when the system supply is seen low and then good again. The supply comparison is taken as a digital "supply good" level.

All intervals are counted in ticks of a time-base strobe from outside the block. The same counters therefore serve a crystal prescaler, a 50 Hz line source or a 60 Hz line source; only the tick rate changes.

Top module: `wdog_pdown`

## Requirements
- R1: After reset, with supply good high: supply-enable, clock-out enable, serial enable and CPU reset (active low) are all 1; the timeout flag and the power-down indication are 0.
- R2: While the watchdog enable is 0, no number of ticks produces a CPU reset or sets the timeout flag.
- R3: With the watchdog enabled and no service, CPU reset goes low and the timeout flag goes high on the SVC_TICKS-th tick after enabling or after the last service, and not before.
- R4: A service is chip enable going high and then low with no rising serial-clock edge while it was high. A service restarts the interval count from zero.
- R5: A chip-enable toggle during which a rising serial-clock edge occurred does not restart the interval count.
- R6: The CPU reset pulse lasts RST_TICKS ticks and then releases. After the release the interval count starts again from zero.
- R7: The timeout flag stays set until a status-read strobe clears it. A timeout in the same cycle as the strobe leaves the flag set.
- R8: A power-down request in the running state enters power-down on the next clock edge. Power-down indication goes 1 and supply-enable, clock-out enable, CPU reset and serial enable all go 0.
- R9: An interrupt input that is high in power-down returns the block to the running state on the next edge.
- R10: In power-down, supply good must be seen low and then high again to leave. Supply good that stays high, or a low/high sequence that came before entry, does not end power-down.
- R11: Supply good low forces supply-enable, clock-out enable and CPU reset to 0 in any state. Serial enable does not depend on supply good.
- R12: The interrupt input has no effect in the running state. A power-down request has no effect while already in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe |
| wd_en | input | 1 | Watchdog enable control bit |
| ce | input | 1 | Chip enable from the host (active high) |
| sck | input | 1 | Serial clock from the host |
| stat_rd | input | 1 | Status-read strobe, clears the timeout flag |
| pd_req | input | 1 | Power-down request strobe |
| irq | input | 1 | Combined alarm, periodic and power-sense interrupt |
| sys_good | input | 1 | System supply good level |
| pse | output | 1 | Power supply enable |
| clk_out_en | output | 1 | Clock output enable |
| cpu_rst_n | output | 1 | Processor reset, active low |
| spi_en | output | 1 | Serial interface enable |
| wd_flag | output | 1 | Sticky watchdog timeout flag |
| pd_active | output | 1 | Power-down state indication |

## Verification
A watchdog timeout and a power-down entry can land in the same clock edge. Both then pull the processor reset low, so the reset must not be released when either one ends. The bench sets the final interval tick and the power-down request in the same cycle. It checks that the flag is set and power-down is entered. It then wakes the block with an interrupt and checks that reset stays low for the rest of the watchdog pulse, releasing only on the last pulse tick. Service placement is swept over every tick offset inside the interval, for both clean and dirty toggles.

// File: rtl/wdog_pdown_pkg.sv
// Package: shared types for the watchdog / power-down block.
// Assumes: nothing beyond the standard language.
package wdog_pdown_pkg;
    typedef enum logic {
        PD_RUN  = 1'b0,
        PD_DOWN = 1'b1
    } pd_state_t;
endpackage

// File: rtl/wdog_svc_det.sv
// Module: wdog_svc_det
// Detects a clean chip-enable service: ce goes high and then low with no
// rising sck edge while ce was high. Emits a one-cycle svc pulse in the cycle
// the falling ce level is first sampled.
// Assumes: ce and sck are already synchronous to clk.
module wdog_svc_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic sck,
    output logic svc
);
    logic ce_q;
    logic sck_q;
    logic dirty;
    logic ce_rise;
    logic ce_fall;
    logic sck_rise;

    // Edge decode of the sampled pins.
    always_comb begin
        ce_rise  = ce & ~ce_q;
        ce_fall  = ~ce & ce_q;
        sck_rise = sck & ~sck_q;
    end

    // Pin history and the "transfer seen" mark for the current ce window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q  <= 1'b0;
            sck_q <= 1'b0;
            dirty <= 1'b0;
        end else begin
            ce_q  <= ce;
            sck_q <= sck;
            if (ce_rise)
                dirty <= sck_rise;
            else if (ce && sck_rise)
                dirty <= 1'b1;
        end
    end

    // Service is a ce window closing without a transfer.
    always_comb svc = ce_fall & ~dirty;

    AST_SVC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        svc |-> (!ce && $past(ce))); // R4
endmodule

// File: rtl/wdog_timer.sv
// Module: wdog_timer
// Counts ticks between services. A timeout starts a reset pulse of
// RST_TICKS ticks and sets a sticky flag, which a status read clears.
// Assumes: tick is a one-cycle strobe; svc is a one-cycle strobe.
module wdog_timer #(
    parameter int SVC_TICKS = 8,
    parameter int RST_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic svc,
    input  logic flag_clr,
    output logic rst_pulse,
    output logic flag
);
    localparam int CW = $clog2(SVC_TICKS + 1);
    localparam int PW = $clog2(RST_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SVC_TICKS - 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(RST_TICKS);

    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;
    logic          pulsing;
    logic          timeout;

    // Timeout fires on the tick that completes the interval.
    always_comb begin
        pulsing = (pcnt != '0);
        timeout = en && tick && !svc && !pulsing && (cnt == CNT_LAST);
    end

    // Interval counter, pulse counter and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
            flag <= 1'b0;
        end else begin
            if (!en || svc || pulsing || timeout)
                cnt <= '0;
            else if (tick)
                cnt <= cnt + CW'(1);

            if (timeout)
                pcnt <= PULSE_LEN;
            else if (pulsing && tick)
                pcnt <= pcnt - PW'(1);

            if (timeout)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end

    always_comb rst_pulse = pulsing;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST); // R3
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pulsing) |=> !pulsing); // R2
    AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulsing) |-> flag); // R7
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pulsing && !tick) |=> pulsing); // R6
endmodule

// File: rtl/pdown_fsm.sv
// Module: pdown_fsm
// Two-state power-down sequencer. Entered by a request strobe; left on any
// interrupt or after the supply has been seen low and then good again.
// Assumes: irq and sys_good are synchronous levels.
module pdown_fsm
    import wdog_pdown_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic irq,
    input  logic sys_good,
    output logic down
);
    pd_state_t state;
    logic      armed;
    logic      wake;

    // Wake on interrupt or on a completed supply low-then-good sequence.
    always_comb wake = irq || (armed && sys_good);

    // State register and supply-low latch (cleared on entry).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PD_RUN;
            armed <= 1'b0;
        end else begin
            case (state)
                PD_RUN: begin
                    armed <= 1'b0;
                    if (pd_req)
                        state <= PD_DOWN;
                end
                PD_DOWN: begin
                    if (wake) begin
                        state <= PD_RUN;
                        armed <= 1'b0;
                    end else if (!sys_good) begin
                        armed <= 1'b1;
                    end
                end
                default: state <= PD_RUN;
            endcase
        end
    end

    always_comb down = (state == PD_DOWN);

    AST_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!down && pd_req) |=> down); // R8
    AST_EXIT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (down && irq) |=> !down); // R9
    AST_STAY_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (down && !irq && !armed) |=> down); // R10
    AST_RUN_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!down && !pd_req) |=> !down); // R12
endmodule

// File: rtl/wdog_pdown.sv
// Module: wdog_pdown (top)
// Chip-enable watchdog plus processor-directed power-down sequencer.
// Combines the watchdog reset pulse, the power-down state and the supply
// level into the four output enables.
// Assumes: all inputs synchronous to clk; tick is a one-cycle strobe.
module wdog_pdown #(
    parameter int SVC_TICKS = 8,
    parameter int RST_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wd_en,
    input  logic ce,
    input  logic sck,
    input  logic stat_rd,
    input  logic pd_req,
    input  logic irq,
    input  logic sys_good,
    output logic pse,
    output logic clk_out_en,
    output logic cpu_rst_n,
    output logic spi_en,
    output logic wd_flag,
    output logic pd_active
);
    logic svc;
    logic wd_pulse;
    logic down;

    wdog_svc_det u_svc (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .sck   (sck),
        .svc   (svc)
    );

    wdog_timer #(
        .SVC_TICKS (SVC_TICKS),
        .RST_TICKS (RST_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .en        (wd_en),
        .svc       (svc),
        .flag_clr  (stat_rd),
        .rst_pulse (wd_pulse),
        .flag      (wd_flag)
    );

    pdown_fsm u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_req   (pd_req),
        .irq      (irq),
        .sys_good (sys_good),
        .down     (down)
    );

    // Output gating: supply and power-down gate the enables, watchdog adds reset.
    always_comb begin
        pse        = sys_good & ~down;
        clk_out_en = sys_good & ~down;
        spi_en     = ~down;
        cpu_rst_n  = sys_good & ~down & ~wd_pulse;
        pd_active  = down;
    end

    AST_PD_OUTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (down && !wd_pulse) |-> (!pse && !clk_out_en && !cpu_rst_n && !spi_en)); // R8
    AST_ROSE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active) |-> $past(pd_req)); // R8
endmodule

// File: tb/wdog_pdown_test.sv
module wdog_pdown_test;
    localparam int SVC = 5;
    localparam int RST = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, wd_en = 0, ce = 0, sck = 0, stat_rd = 0;
    logic pd_req = 0, irq = 0, sys_good = 1;
    logic pse, clk_out_en, cpu_rst_n, spi_en, wd_flag, pd_active;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdog_pdown #(.SVC_TICKS(SVC), .RST_TICKS(RST)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wd_en(wd_en), .ce(ce),
        .sck(sck), .stat_rd(stat_rd), .pd_req(pd_req), .irq(irq),
        .sys_good(sys_good), .pse(pse), .clk_out_en(clk_out_en),
        .cpu_rst_n(cpu_rst_n), .spi_en(spi_en), .wd_flag(wd_flag),
        .pd_active(pd_active)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1; step(); tick = 1'b0;
    endtask

    task automatic service(input bit dirty);
        ce = 1'b1; step();
        if (dirty) begin
            sck = 1'b1; step(); sck = 1'b0; step();
        end
        ce = 1'b0; step();
    endtask

    // Let a running pulse finish and clear the flag.
    task automatic recover();
        for (int i = 0; i < RST; i++) do_tick();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        service(1'b0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 pse", pse, 1'b1);
        chk("R1 clk_out_en", clk_out_en, 1'b1);
        chk("R1 spi_en", spi_en, 1'b1);
        chk("R1 cpu_rst_n", cpu_rst_n, 1'b1);
        chk("R1 wd_flag", wd_flag, 1'b0);
        chk("R1 pd_active", pd_active, 1'b0);

        // R2 disabled watchdog never fires
        for (int i = 0; i < 3 * SVC; i++) do_tick();
        chk("R2 cpu_rst_n", cpu_rst_n, 1'b1);
        chk("R2 wd_flag", wd_flag, 1'b0);

        // R3 timeout on the SVC-th tick; R6 pulse length and restart
        wd_en = 1'b1; step();
        for (int t = 1; t <= SVC; t++) begin
            do_tick();
            chk($sformatf("R3 rst t=%0d", t), cpu_rst_n, (t < SVC));
            chk($sformatf("R3 flag t=%0d", t), wd_flag, (t >= SVC));
        end
        for (int r = 1; r <= RST; r++) begin
            do_tick();
            chk($sformatf("R6 pulse r=%0d", r), cpu_rst_n, (r == RST));
        end
        chk("R7 flag sticky", wd_flag, 1'b1);
        for (int t = 1; t < SVC; t++) do_tick();
        chk("R6 restart from zero", cpu_rst_n, 1'b1);
        do_tick();
        chk("R6 next timeout", cpu_rst_n, 1'b0);
        recover();
        chk("R7 flag cleared", wd_flag, 1'b0);

        // R4 clean service at every offset restarts the count
        for (int k = 1; k < SVC; k++) begin
            for (int i = 0; i < k; i++) do_tick();
            service(1'b0);
            for (int i = 1; i < SVC; i++) do_tick();
            chk($sformatf("R4 k=%0d no rst", k), cpu_rst_n, 1'b1);
            do_tick();
            chk($sformatf("R4 k=%0d rst", k), cpu_rst_n, 1'b0);
            recover();
        end

        // R5 dirty toggle at every offset does not restart
        for (int k = 1; k < SVC; k++) begin
            for (int i = 0; i < k; i++) do_tick();
            service(1'b1);
            for (int i = k + 1; i < SVC; i++) do_tick();
            chk($sformatf("R5 k=%0d before", k), cpu_rst_n, 1'b1);
            do_tick();
            chk($sformatf("R5 k=%0d rst", k), cpu_rst_n, 1'b0);
            recover();
        end

        // R7 clear and timeout in the same cycle: set wins
        for (int i = 1; i < SVC; i++) do_tick();
        stat_rd = 1'b1; tick = 1'b1; step(); stat_rd = 1'b0; tick = 1'b0;
        chk("R7 set beats clear", wd_flag, 1'b1);
        recover();

        // Concurrency: timeout and power-down entry on the same edge
        for (int i = 1; i < SVC; i++) do_tick();
        tick = 1'b1; pd_req = 1'b1; step(); tick = 1'b0; pd_req = 1'b0;
        chk("R8 pd on timeout edge", pd_active, 1'b1);
        chk("R3 flag on pd edge", wd_flag, 1'b1);
        chk("R8 rst low", cpu_rst_n, 1'b0);
        irq = 1'b1; step(); irq = 1'b0;
        chk("R9 woke", pd_active, 1'b0);
        chk("R6 rst held after wake", cpu_rst_n, 1'b0);
        for (int r = 1; r <= RST; r++) begin
            do_tick();
            chk($sformatf("R6 overlap r=%0d", r), cpu_rst_n, (r == RST));
        end
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
        wd_en = 1'b0; step();

        // R12 irq in running state has no effect
        irq = 1'b1; step(); step(); irq = 1'b0;
        chk("R12 irq in run", pd_active, 1'b0);
        chk("R12 pse in run", pse, 1'b1);

        // R8 entry and outputs
        pd_req = 1'b1; step(); pd_req = 1'b0;
        chk("R8 pd_active", pd_active, 1'b1);
        chk("R8 pse", pse, 1'b0);
        chk("R8 clk_out_en", clk_out_en, 1'b0);
        chk("R8 cpu_rst_n", cpu_rst_n, 1'b0);
        chk("R8 spi_en", spi_en, 1'b0);
        pd_req = 1'b1; step(); pd_req = 1'b0;
        chk("R12 req in down", pd_active, 1'b1);
        // R10 supply staying good does not wake
        repeat (5) step();
        chk("R10 stays down", pd_active, 1'b1);
        sys_good = 1'b0; step(); step();
        chk("R10 still down while low", pd_active, 1'b1);
        sys_good = 1'b1; step();
        chk("R10 wake on good", pd_active, 1'b0);
        chk("R10 pse back", pse, 1'b1);
        chk("R10 spi back", spi_en, 1'b1);

        // R10 low/high before entry does not count
        sys_good = 1'b0; step();
        // R11 supply low gates outputs in running state
        chk("R11 pse", pse, 1'b0);
        chk("R11 clk_out_en", clk_out_en, 1'b0);
        chk("R11 cpu_rst_n", cpu_rst_n, 1'b0);
        chk("R11 spi_en", spi_en, 1'b1);
        sys_good = 1'b1; step();
        pd_req = 1'b1; step(); pd_req = 1'b0;
        repeat (3) step();
        chk("R10 stale sequence ignored", pd_active, 1'b1);
        // R9 interrupt wake
        irq = 1'b1; step(); irq = 1'b0;
        chk("R9 irq wake", pd_active, 1'b0);
        chk("R9 cpu_rst_n", cpu_rst_n, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule